// File: doc/BRIEF.md
# Operating-System Timer with Timestamp Counter

This block pairs a free-running timestamp counter with a single down-counting event timer. The timestamp counter advances by one on every clock and wraps freely, so software can read it as a monotonic time base. Software may also overwrite it, for example with zero to restart the count. The event timer is loaded with a reload count. It counts down to zero and then expires. In periodic mode it reloads and keeps running. In one-shot mode it stops after its single expiry. Each expiry sets a pending bit, and the interrupt output follows that bit until software clears it by writing 1 to the status register.

A small register port handles both reads and writes. Address 0 is the timestamp. Address 1 is the combined reload/control register. Address 2 is the status register. Address 3 reads as zero. The reload count and the control flags share one word: the two lowest bits are control, and the reload count uses the bits above them.

The event timer is a three-state machine:
- `ST_OFF`: disabled.
- `ST_COUNT`: counting down.
- `ST_DONE`: a one-shot has finished.

Its transitions are:
- *arm*: any state goes to `ST_COUNT` on a reload write with enable set.
- *disarm*: any state goes to `ST_OFF` on a reload write with enable clear.
- *wrap*: `ST_COUNT` stays in `ST_COUNT` on a periodic expiry.
- *finish*: `ST_COUNT` goes to `ST_DONE` on a one-shot expiry.

Top module: `ostmr_top`

## Requirements
- R1: When no write targets address 0, the timestamp read at address 0 increases by exactly one per clock and wraps from 0xFFFFFFFF to 0.
- R2: A write to address 0 loads the written value into the timestamp. It reads back on the next cycle and counts on from there.
- R3: The reload/control register at address 1 reads back as follows: bit 0 is enable, bit 1 is one-shot, and bits 31:2 hold the reload count. The low two bits of the count itself are always zero.
- R4: A write to address 1 with enable set loads the down-counter with the reload count R at once. The pending bit then rises on the (R+1)th clock edge after the write edge.
- R5: In periodic mode (bit 1 = 0), the timer expires again every R+1 cycles without further writes.
- R6: In one-shot mode (bit 1 = 1), the timer expires once. It then stops, its enable bit reads 0, and no further expiry occurs.
- R7: Writing 0 to address 1 disables the timer. No expiry follows, and the register reads 0.
- R8: The pending bit is bit 0 of the status register at address 2. Writing 1 to that bit clears it on the next edge; writing 0 leaves it unchanged.
- R9: The interrupt output equals the pending bit. It stays high from an expiry until it is cleared.
- R10: When an expiry and a clear write fall on the same edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register address (0 timestamp, 1 reload/control, 2 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Timer interrupt, equal to the pending bit |

## Verification
Read data is combinational, so a register value written on edge E is visible from the falling edge after E. The pending bit and the interrupt are registered at the expiry edge. With reload count R, they rise R+1 edges after the write edge. The driver issues every write on a falling edge and samples half a cycle after each rising edge. It then pushes the expected value into a scoreboard queue at the exact edge where the count above says the change lands. A monitor pops and compares each expected value against the captured one, so a result that arrives one cycle early or late fails.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } tmr_state_e;

    localparam logic [1:0] A_STAMP  = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_STATUS = 2'd2;

    localparam int CTL_EN      = 0;
    localparam int CTL_ONESHOT = 1;
endpackage

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assign value = cnt_q;

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (value == $past(value) + 1'b1)); // R1
    AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(load_val))); // R2
endmodule

// File: rtl/ostmr_down.sv
module ostmr_down
    import ostmr_pkg::*;
#(
    parameter int W  = 32,
    parameter int CB = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_val,
    output logic [W-1:0] cfg_rd,
    output logic         expire
);
    localparam int RW = W - CB;

    tmr_state_e   state_q, state_d;
    logic [W-1:0] reload_q, cnt_q, wr_count;
    logic         en_q, os_q;

    assign wr_count = {cfg_val[W-1:CB], {CB{1'b0}}};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = ST_OFF;
            ST_COUNT: if (cnt_q == '0) state_d = os_q ? ST_DONE : ST_COUNT;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_OFF;
        endcase
        if (cfg_wr) state_d = cfg_val[CTL_EN] ? ST_COUNT : ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            en_q     <= 1'b0;
            os_q     <= 1'b0;
        end else if (cfg_wr) begin
            reload_q <= wr_count;
            cnt_q    <= wr_count;
            en_q     <= cfg_val[CTL_EN];
            os_q     <= cfg_val[CTL_ONESHOT];
        end else if (state_q == ST_COUNT) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_q;
                if (os_q) en_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        expire = (state_q == ST_COUNT) && (cnt_q == '0);
        cfg_rd = {reload_q[W-1:CB], {CB{1'b0}}};
        cfg_rd[CTL_EN]      = en_q;
        cfg_rd[CTL_ONESHOT] = os_q;
    end

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cnt_q == reload_q && reload_q[RW+CB-1:CB] == $past(cfg_val[W-1:CB]))); // R4
    AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !os_q && !cfg_wr) |=> (state_q == ST_COUNT && cnt_q == reload_q)); // R5
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && os_q && !cfg_wr) |=> (state_q == ST_DONE && !en_q)); // R6
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_val == '0) |=> (state_q == ST_OFF && cfg_rd == '0)); // R7
endmodule

// File: rtl/ostmr_regs.sv
module ostmr_regs
    import ostmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] stamp_val,
    input  logic [W-1:0] cfg_rd,
    input  logic         expire,
    output logic         stamp_wr,
    output logic         cfg_wr,
    output logic [W-1:0] rdata,
    output logic         pend
);
    logic pend_q, clr;

    assign stamp_wr = wr_en && (addr == A_STAMP);
    assign cfg_wr   = wr_en && (addr == A_RELOAD);
    assign clr      = wr_en && (addr == A_STATUS) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
        else if (clr)    pend_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_STAMP:  rdata = stamp_val;
            A_RELOAD: rdata = cfg_rd;
            A_STATUS: rdata[0] = pend_q;
            default:  rdata = '0;
        endcase
    end

    assign pend = pend_q;

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr) |=> pend_q); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q); // R10
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !pend_q); // R8
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int W  = 32,
    parameter int CB = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq
);
    logic [W-1:0] stamp_val, cfg_rd;
    logic         stamp_wr, cfg_wr, expire, pend;

    ostmr_stamp #(.W(W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .load(stamp_wr), .load_val(wdata), .value(stamp_val)
    );

    ostmr_down #(.W(W), .CB(CB)) u_down (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(wdata),
        .cfg_rd(cfg_rd), .expire(expire)
    );

    ostmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .stamp_val(stamp_val), .cfg_rd(cfg_rd), .expire(expire),
        .stamp_wr(stamp_wr), .cfg_wr(cfg_wr), .rdata(rdata), .pend(pend)
    );

    assign irq = pend;
endmodule

// File: tb/ostmr_top_bench.sv
`timescale 1ns/1ps
module ostmr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    ostmr_top u_ostmr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic sample(input logic [1:0] a, input logic [31:0] e, input string tag);
        addr = a;
        #1;
        exp_q.push_back('{tag, e});
        act_q.push_back('{tag, rdata});
    endtask

    task automatic sample_irq(input logic e, input string tag);
        #1;
        exp_q.push_back('{tag, {31'b0, e}});
        act_q.push_back('{tag, {31'b0, irq}});
    endtask

    initial begin
        forever begin
            wait (exp_q.size() > 0 && act_q.size() > 0);
            begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_chk++;
                if (a.val !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", e.tag, a.val, e.val);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        sample(2'd1, 32'h0, "reset");
        sample(2'd2, 32'h0, "reset");
        sample_irq(1'b0, "reset");

        // R2 load and R1 count on, wrap
        wr(2'd0, 32'd100);
        sample(2'd0, 32'd100, "R2");
        tick(1);
        sample(2'd0, 32'd101, "R1");
        wr(2'd0, 32'hFFFF_FFFF);
        sample(2'd0, 32'hFFFF_FFFF, "R2");
        tick(1);
        sample(2'd0, 32'h0, "R1");
        wr(2'd0, 32'h0);
        sample(2'd0, 32'h0, "R2");

        // R3 readback, R4 first expiry at edge R+1 (R=16)
        wr(2'd1, 32'h11);
        sample(2'd1, 32'h11, "R3");
        for (int i = 0; i < 16; i++) begin
            tick(1);
            sample_irq(1'b0, "R4");
        end
        tick(1);
        sample_irq(1'b1, "R4");
        sample(2'd2, 32'h1, "R8");
        wr(2'd2, 32'h0);
        sample_irq(1'b1, "R8");
        sample_irq(1'b1, "R9");
        wr(2'd2, 32'h1);
        sample_irq(1'b0, "R8");
        for (int i = 0; i < 14; i++) begin
            tick(1);
            sample_irq(1'b0, "R5");
        end
        tick(1);
        sample_irq(1'b1, "R5");

        // R7 disable
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1);
        sample(2'd1, 32'h0, "R7");
        tick(40);
        sample_irq(1'b0, "R7");

        // R6 one-shot, R=8
        wr(2'd1, 32'h0B);
        sample(2'd1, 32'h0B, "R3");
        for (int i = 0; i < 8; i++) begin
            tick(1);
            sample_irq(1'b0, "R6");
        end
        tick(1);
        sample_irq(1'b1, "R6");
        sample(2'd1, 32'h0A, "R6");
        wr(2'd2, 32'h1);
        tick(30);
        sample_irq(1'b0, "R6");

        // R10 expiry every cycle vs clear on same edge
        wr(2'd1, 32'h01);
        tick(2);
        wr(2'd2, 32'h1);
        sample_irq(1'b1, "R10");
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1);
        sample_irq(1'b0, "R7");
        sample(2'd3, 32'h0, "R3");

        wait (exp_q.size() == 0);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule